// File: doc/BRIEF.md
# Raster-Operation Block Copy Engine

This engine moves a rectangle of bytes inside a byte-addressed video memory. It fetches each source byte, fetches the matching destination byte, and writes back a two-operand Boolean combination of the two. The caller picks that combination with an 8-bit code. The rectangle is described by a source base, a destination base, a width in bytes, a height in rows and one row pitch for each side. A start pulse captures all of these, so the inputs may change freely while the engine runs.

A direction bit chooses the walk. In forward mode the engine goes down the rows and up the addresses within a row. In backward mode both pitches are taken as negative and each row is walked toward lower addresses, starting at the programmed bases. This lets a caller shift a region onto an overlapping copy of itself without corrupting it. The memory side is a single synchronous port with one access in flight. Read data comes back the cycle after a read request.

Top module: `blit_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are all low.
- R2: In forward mode, byte (row r, column c) uses source address `src_base + r*src_pitch + c` and destination address `dst_base + r*dst_pitch + c`, modulo 2^AW. Rows go from 0 upward, and columns go from 0 upward within each row.
- R3: In backward mode the addresses are `src_base - r*src_pitch - c` and `dst_base - r*dst_pitch - c`, modulo 2^AW, in the same row and column order as R2.
- R4: Each byte takes three back-to-back accesses: a source read, a destination read, then a write (`mem_we`=1) to the destination address. The reply to a read is taken from `mem_rdata` in the cycle after the request, and exactly 3*width*height accesses are made.
- R5: The value written is f(S,D), where S is the source byte and D is the destination byte read for that position. The code-to-function map is:
  - 0x00 → 0
  - 0x05 → S&D
  - 0x09 → S&~D
  - 0x0B → ~D
  - 0x0D → S
  - 0x0E → 0xFF
  - 0x50 → ~S&D
  - 0x59 → S^D
  - 0x6D → S|D
  - 0x90 → ~S|~D
  - 0x95 → ~(S^D)
  - 0xAD → S|~D
  - 0xD0 → ~S
  - 0xD6 → ~S|D
  - 0xDA → ~S&~D
- R6: Code 0x06 (keep destination) and every code not listed in R5 make no memory access. `busy` stays low, and `done` is high for one cycle in the cycle after the start edge.
- R7: A start with width 0 or height 0 is rejected in the same way as R6: no access, `busy` low, and a one-cycle `done`.
- R8: For an accepted start, `busy` is high from the cycle after the start edge. `done` pulses for exactly one cycle in the cycle after the last write, and `busy` is low in that cycle.
- R9: A `start` while `busy` is high is ignored. Changes to the configuration inputs during a run do not alter that run's accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| src_base | input | AW | First source byte address |
| dst_base | input | AW | First destination byte address |
| width | input | LW | Bytes per row |
| height | input | LW | Number of rows |
| src_pitch | input | AW | Source row stride (magnitude) |
| dst_pitch | input | AW | Destination row stride (magnitude) |
| backward | input | 1 | Walk toward lower addresses |
| rop_code | input | 8 | Raster-operation selector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read request |

## Verification
The assertions take three things for granted about the environment:
- `rst_n` is held low across at least one clock edge before any activity.
- The memory answers every read with fixed one-cycle latency.
- `start` is a synchronous level sampled at the clock edge.

The bench keeps to these assumptions. It models the memory as a registered array, it drives every input on the falling edge, and it raises `start` for single cycles. These single-cycle pulses include a deliberate one during a run, which the engine has to ignore.

// File: rtl/blit_pkg.sv
// Shared definitions for the block copy engine: controller states and
// the truth-table encoding of the raster operations.
// Assumes two-operand operations on bytes; the truth table is indexed by {src_bit, dst_bit}.
package blit_pkg;
    localparam int TT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_SRC,
        ST_RD_DST,
        ST_WRITE
    } blit_state_t;

    // Truth table that reproduces the destination bit: the "keep" operation.
    localparam logic [TT_W-1:0] TT_KEEP = 4'b1010;
endpackage

// File: rtl/blit_rop_decode.sv
// Maps an 8-bit raster-operation code to a 4-entry truth table.
// Assumes nothing about the code: unknown codes decode to the keep-destination table.
module blit_rop_decode
    import blit_pkg::*;
(
    input  logic [7:0]      code,
    output logic [TT_W-1:0] tt,
    output logic            keep
);
    // Code lookup; bit index {s,d}: 3=(1,1) 2=(1,0) 1=(0,1) 0=(0,0).
    always_comb begin
        case (code)
            8'h00:   tt = 4'b0000;
            8'h05:   tt = 4'b1000;
            8'h09:   tt = 4'b0100;
            8'h0B:   tt = 4'b0101;
            8'h0D:   tt = 4'b1100;
            8'h0E:   tt = 4'b1111;
            8'h50:   tt = 4'b0010;
            8'h59:   tt = 4'b0110;
            8'h6D:   tt = 4'b1110;
            8'h90:   tt = 4'b0111;
            8'h95:   tt = 4'b1001;
            8'hAD:   tt = 4'b1101;
            8'hD0:   tt = 4'b0011;
            8'hD6:   tt = 4'b1011;
            8'hDA:   tt = 4'b0001;
            default: tt = TT_KEEP;
        endcase
    end

    // The keep table needs no memory traffic at all.
    assign keep = (tt == TT_KEEP);
endmodule

// File: rtl/blit_rop_alu.sv
// Bitwise two-operand function: each result bit selects a truth-table
// entry with its source and destination bits.
// Assumes the truth table is stable while the result is used.
module blit_rop_alu
    import blit_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [TT_W-1:0] tt,
    input  logic [DW-1:0]   src,
    input  logic [DW-1:0]   dst,
    output logic [DW-1:0]   result
);
    // One 4:1 selector per data bit.
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign result[i] = tt[{src[i], dst[i]}];
    end
endmodule

// File: rtl/blit_addr_gen.sv
// Rectangle walker: holds the row bases and the column/row counters, and
// produces the current source and destination byte addresses.
// Assumes width and height are nonzero when load is raised.
// Arithmetic wraps modulo 2^AW.
module blit_addr_gen #(
    parameter int AW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [LW-1:0] width,
    input  logic [LW-1:0] height,
    input  logic [AW-1:0] src_pitch,
    input  logic [AW-1:0] dst_pitch,
    input  logic          backward,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          last
);
    localparam logic [LW-1:0] ONE = LW'(1);

    logic [AW-1:0] src_row, dst_row, sp_q, dp_q;
    logic [LW-1:0] col, row, w_q, h_q;
    logic          bwd_q;
    logic          row_end;
    logic [AW-1:0] col_off;

    assign row_end = (col == w_q - ONE);
    assign last    = row_end && (row == h_q - ONE);
    assign col_off = AW'(col);

    // Byte address: row base moved by the column, in the chosen direction.
    assign src_addr = bwd_q ? src_row - col_off : src_row + col_off;
    assign dst_addr = bwd_q ? dst_row - col_off : dst_row + col_off;

    // Capture the rectangle at load, then advance one byte per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_row <= '0;
            dst_row <= '0;
            sp_q    <= '0;
            dp_q    <= '0;
            col     <= '0;
            row     <= '0;
            w_q     <= '0;
            h_q     <= '0;
            bwd_q   <= 1'b0;
        end else if (load) begin
            src_row <= src_base;
            dst_row <= dst_base;
            sp_q    <= src_pitch;
            dp_q    <= dst_pitch;
            col     <= '0;
            row     <= '0;
            w_q     <= width;
            h_q     <= height;
            bwd_q   <= backward;
        end else if (step) begin
            if (row_end) begin
                col     <= '0;
                row     <= row + ONE;
                src_row <= bwd_q ? src_row - sp_q : src_row + sp_q;
                dst_row <= bwd_q ? dst_row - dp_q : dst_row + dp_q;
            end else begin
                col <= col + ONE;
            end
        end
    end
endmodule

// File: rtl/blit_engine.sv
// Top of the block copy engine. The controller runs three accesses per byte:
// a source read, a destination read, then a combined write.
// Assumes the memory returns read data exactly one cycle after the request.
module blit_engine
    import blit_pkg::*;
#(
    parameter int AW = 16,
    parameter int LW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [LW-1:0] width,
    input  logic [LW-1:0] height,
    input  logic [AW-1:0] src_pitch,
    input  logic [AW-1:0] dst_pitch,
    input  logic          backward,
    input  logic [7:0]    rop_code,
    output logic          busy,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata
);
    blit_state_t     state;
    logic [TT_W-1:0] tt_in, tt_q;
    logic            keep_in;
    logic [DW-1:0]   src_q;
    logic            accept, reject, last;
    logic [AW-1:0]   src_addr, dst_addr;

    blit_rop_decode u_dec (
        .code (rop_code),
        .tt   (tt_in),
        .keep (keep_in)
    );

    blit_rop_alu #(.DW(DW)) u_alu (
        .tt     (tt_q),
        .src    (src_q),
        .dst    (mem_rdata),
        .result (mem_wdata)
    );

    blit_addr_gen #(.AW(AW), .LW(LW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (state == ST_WRITE),
        .src_base  (src_base),
        .dst_base  (dst_base),
        .width     (width),
        .height    (height),
        .src_pitch (src_pitch),
        .dst_pitch (dst_pitch),
        .backward  (backward),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .last      (last)
    );

    // Start qualification: a keep operation or an empty rectangle finishes at once.
    assign reject = keep_in || (width == '0) || (height == '0);
    assign accept = (state == ST_IDLE) && start && !reject;

    // Memory port drive, decoded from the controller state.
    assign busy     = (state != ST_IDLE);
    assign mem_req  = busy;
    assign mem_we   = (state == ST_WRITE);
    assign mem_addr = (state == ST_RD_SRC) ? src_addr : dst_addr;

    // Controller sequencing and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            tt_q  <= TT_KEEP;
            src_q <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && reject) begin
                        done <= 1'b1;
                    end else if (start) begin
                        tt_q  <= tt_in;
                        state <= ST_RD_SRC;
                    end
                end
                ST_RD_SRC: state <= ST_RD_DST;
                ST_RD_DST: begin
                    src_q <= mem_rdata;
                    state <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_RD_SRC;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blit_engine_chk.sv
// Protocol checker for the block copy engine, attached by bind.
// Assumes a synchronous active-low reset held across at least one clock edge.
module blit_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic mem_req,
    input logic mem_we
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

    p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req) && !$past(mem_we)));

    p_first_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));
endmodule

bind blit_engine blit_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .mem_req (mem_req),
    .mem_we  (mem_we)
);

// File: tb/blit_engine_tb_top.sv
`timescale 1ns/1ps
module blit_engine_tb_top;
    localparam int AW = 12;
    localparam int LW = 8;
    localparam int DW = 8;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0, src_pitch = '0, dst_pitch = '0;
    logic [LW-1:0] width = '0, height = '0;
    logic          backward = 1'b0;
    logic [7:0]    rop_code = 8'h00;
    logic          busy, done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;

    logic [7:0] mem [MSZ];
    logic [7:0] exp_mem [MSZ];

    typedef struct {
        bit    we;
        int    addr;
        int    data;
        string tag;
    } acc_t;
    acc_t sb_q[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    blit_engine #(.AW(AW), .LW(LW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .width(width), .height(height),
        .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .backward(backward), .rop_code(rop_code),
        .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr];
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every access against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6", "unexpected access addr", int'(mem_addr), -1);
            end else begin
                acc_t e;
                e = sb_q.pop_front();
                check(mem_we == e.we, "R4", "access kind", int'(mem_we), int'(e.we));
                check(int'(mem_addr) == e.addr, e.tag, "access addr", int'(mem_addr), e.addr);
                if (e.we) check(int'(mem_wdata) == e.data, "R5", "write data", int'(mem_wdata), e.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit known(input logic [7:0] c);
        case (c)
            8'h00, 8'h05, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50, 8'h59,
            8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] rop_ref(input logic [7:0] c, input logic [7:0] s, input logic [7:0] d);
        case (c)
            8'h00: return 8'h00;
            8'h05: return s & d;
            8'h09: return s & ~d;
            8'h0B: return ~d;
            8'h0D: return s;
            8'h0E: return 8'hFF;
            8'h50: return ~s & d;
            8'h59: return s ^ d;
            8'h6D: return s | d;
            8'h90: return ~s | ~d;
            8'h95: return ~(s ^ d);
            8'hAD: return s | ~d;
            8'hD0: return ~s;
            8'hD6: return ~s | d;
            8'hDA: return ~s & ~d;
            default: return d;
        endcase
    endfunction

    // Driver: push the expected accesses, pulse start, wait for completion.
    task automatic run_blit(input int sb, input int db, input int w, input int h,
                            input int sp, input int dp, input bit bwd,
                            input logic [7:0] code, input int poke_at);
        bit active;
        string tag;
        active = known(code) && (w > 0) && (h > 0);
        tag = bwd ? "R3" : "R2";
        if (active) begin
            for (int r = 0; r < h; r++) begin
                for (int c = 0; c < w; c++) begin
                    int sa, da;
                    logic [7:0] res;
                    sa = bwd ? (sb - r*sp - c) : (sb + r*sp + c);
                    da = bwd ? (db - r*dp - c) : (db + r*dp + c);
                    sa = sa & (MSZ - 1);
                    da = da & (MSZ - 1);
                    res = rop_ref(code, exp_mem[sa], exp_mem[da]);
                    sb_q.push_back('{1'b0, sa, 0, tag});
                    sb_q.push_back('{1'b0, da, 0, tag});
                    sb_q.push_back('{1'b1, da, int'(res), tag});
                    exp_mem[da] = res;
                end
            end
        end
        @(negedge clk);
        src_base = AW'(sb); dst_base = AW'(db);
        width = LW'(w); height = LW'(h);
        src_pitch = AW'(sp); dst_pitch = AW'(dp);
        backward = bwd; rop_code = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!active) begin
            check(done == 1'b1, (w == 0 || h == 0) ? "R7" : "R6", "done after start", int'(done), 1);
            check(busy == 1'b0, (w == 0 || h == 0) ? "R7" : "R6", "busy after start", int'(busy), 0);
            @(negedge clk);
            check(done == 1'b0, "R8", "done width", int'(done), 0);
        end else begin
            bit seen;
            check(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
            seen = 1'b0;
            for (int k = 1; k < 20000 && !seen; k++) begin
                if (k == poke_at) begin
                    start = 1'b1;
                    src_base = ~src_base; dst_base = ~dst_base;
                    rop_code = 8'h0E; width = 8'd1; backward = ~bwd;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            start = 1'b0;
            check(seen, "R8", "done seen", int'(seen), 1);
            check(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
            check(sb_q.size() == 0, poke_at > 0 ? "R9" : "R4", "pending accesses", sb_q.size(), 0);
            @(negedge clk);
            check(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        end
    endtask

    initial begin
        logic [7:0] codes [16];
        codes = '{8'h00, 8'h05, 8'h06, 8'h09, 8'h0B, 8'h0D, 8'h0E, 8'h50,
                  8'h59, 8'h6D, 8'h90, 8'h95, 8'hAD, 8'hD0, 8'hD6, 8'hDA};
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = 8'((i * 37 + 5) ^ (i >> 4));
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && mem_req == 1'b0, "R1", "idle after reset", int'(busy), 0);

        // R2: forward copy with distinct pitches
        run_blit(12'h010, 12'h800, 5, 4, 24, 40, 1'b0, 8'h0D, 0);
        // R5: every code (0x06 among them exercises R6)
        for (int i = 0; i < 16; i++)
            run_blit(12'h100 + i*8, 12'h400 + i*16, 3, 2, 32, 48, 1'b0, codes[i], 0);
        // R3: backward, overlapping shift and a second pattern
        run_blit(12'h905, 12'h907, 6, 3, 16, 16, 1'b1, 8'h0D, 0);
        run_blit(12'hA40, 12'hB80, 4, 5, 20, 12, 1'b1, 8'h59, 0);
        // R2: address wrap at the top of memory
        run_blit(12'h300, 12'hFFE, 4, 2, 8, 8, 1'b0, 8'hD6, 0);
        // R3: wrap below zero in backward mode
        run_blit(12'h600, 12'h001, 3, 2, 8, 4, 1'b1, 8'hDA, 0);
        // R6: unknown code
        run_blit(12'h010, 12'h020, 4, 4, 16, 16, 1'b0, 8'h42, 0);
        // R7: empty rectangles
        run_blit(12'h010, 12'h020, 0, 4, 16, 16, 1'b0, 8'h0D, 0);
        run_blit(12'h010, 12'h020, 4, 0, 16, 16, 1'b0, 8'h0D, 0);
        // R9: start and new configuration mid-run
        run_blit(12'h200, 12'hC00, 4, 3, 16, 16, 1'b0, 8'h6D, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule